// File: doc/BRIEF.md
# Watchpoint Address Comparator Bank

This block watches the data-access bus of a processor with a small bank of comparators. Each comparator holds a 32-bit reference word, a 5-bit ignore count that blanks the low address bits so one setting covers an aligned address window, and a control word. The control word picks one of three kinds of comparison: an access address, an access data value of a given width, or (on comparator 0 only) the running cycle count.

A hit drives a one-clock pulse on that comparator's output in the same cycle as the access that caused it. The hit also sets a sticky flag in the control word. Software clears the flag by reading that word.

Configuration uses a plain register port with separate read and write strobes. Read data is combinational for the cycle in which the read strobe is high.

Top module: `wpt_bank`

## Requirements
- R1: After reset every register of every comparator reads 0 and no match pulse is driven.
- R2: Comparator n (n = 0..3) owns three words. The reference is at byte address 0x20+16n and holds all 32 bits. The ignore count is at 0x24+16n and holds bits 4:0, with the upper bits reading 0. The control word is at 0x28+16n. The word at 0x2C+16n, and any address outside these words, reads 0 and ignores writes.
- R3: Address mode is control bit 8 = 0. A comparator hits on a valid access whose address equals the reference in every bit at or above position k, where k is the ignore count clamped to at most 15.
- R4: A comparator whose action field (control bits 3:0) is 0 never hits and never sets its flag.
- R5: A hit drives match_pulse[n] high in the same cycle as the access. The flag (control bit 24) is set at the following clock edge and stays set until it is cleared by a read.
- R6: Reading the control word returns the flag and clears it at that clock edge. If a new hit happens in the same cycle as the read, the flag stays set.
- R7: Data-value mode is control bit 8 = 1. The size code in control bits 11:10 is 0 for a byte, 1 for a halfword, 2 for a word, and 3 never hits. acc_size uses the same encoding and must equal the size code. The low 8, 16 or 32 bits of acc_data and the reference must then be equal, and the address plays no part.
- R8: Control bit 7 on comparator 0 selects cycle mode. In this mode the comparator checks cyc_count against the reference every cycle, with the same low-bit clamp as R3 and with no access needed; bit 8 is ignored. On comparators 1 to 3, bit 7 reads 0 and has no effect.
- R9: The control word stores only bits 3:0, 7, 8 and 11:10. All other bits except the flag read 0, and writing the control word leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a read flag) |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while reg_rd is high |
| acc_valid | input | 1 | A data access is present this cycle |
| acc_addr | input | 32 | Access address |
| acc_data | input | 32 | Access data value |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cyc_count | input | 32 | Current cycle counter value |
| match_pulse | output | 4 | Per-comparator one-clock hit pulse |

## Verification
The hardest case to reach is a read of the control word in the very cycle in which a fresh hit arrives. Here the clear and the set collide, and only a later read can show which one won. The bench drives the read strobe and a matching access on the same falling edge. It checks that this read shows the flag, then reads again to prove the flag survived, and reads a third time to see it clear. The ignore count is swept over all 32 codes, with single-bit address flips at every low position, so the clamp at 15 is observed from the ports.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SHIFT_W = 5;
  localparam int unsigned FN_CYC   = 7;
  localparam int unsigned FN_DMODE = 8;
  localparam int unsigned FN_DSZ   = 10;
  localparam int unsigned FN_FLAG  = 24;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } vsize_e;

  function automatic logic [SHIFT_W-1:0] clamp_shift(input logic [SHIFT_W-1:0] cnt,
                                                    input logic [SHIFT_W-1:0] lim);
    return (cnt > lim) ? lim : cnt;
  endfunction

  function automatic word_t upper_keep(input logic [SHIFT_W-1:0] shift);
    return ~((word_t'(1) << shift) - word_t'(1));
  endfunction

  function automatic word_t size_keep(input vsize_e sz);
    case (sz)
      SZ_BYTE: return word_t'(32'h0000_00FF);
      SZ_HALF: return word_t'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic window_hit(input word_t a, input word_t r,
                                      input logic [SHIFT_W-1:0] shift);
    return ((a ^ r) & upper_keep(shift)) == '0;
  endfunction

  function automatic logic value_hit(input word_t d, input word_t r,
                                     input vsize_e want, input logic [1:0] got);
    return (want != SZ_NONE) && (got == want) && (((d ^ r) & size_keep(want)) == '0);
  endfunction
endpackage

// File: rtl/wpt_decode.sv
module wpt_decode #(
  parameter int unsigned NUM_CMP    = 4,
  parameter int unsigned BUS_AW     = 8,
  parameter int unsigned REG_BASE   = 32,
  parameter int unsigned REG_STRIDE = 16
) (
  input  logic [BUS_AW-1:0]  reg_addr,
  output logic [NUM_CMP-1:0] sel_ref,
  output logic [NUM_CMP-1:0] sel_mask,
  output logic [NUM_CMP-1:0] sel_func
);
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_sel
    localparam int unsigned OFS = REG_BASE + i * REG_STRIDE;
    assign sel_ref[i]  = (reg_addr == BUS_AW'(OFS));
    assign sel_mask[i] = (reg_addr == BUS_AW'(OFS + 4));
    assign sel_func[i] = (reg_addr == BUS_AW'(OFS + 8));
  end
endmodule

// File: rtl/wpt_slot.sv
module wpt_slot
  import wpt_pkg::*;
#(
  parameter bit                   HAS_CYC    = 1'b0,
  parameter logic [SHIFT_W-1:0]   MASK_LIMIT = 5'd15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ref,
  input  logic        wr_mask,
  input  logic        wr_func,
  input  logic        rd_func,
  input  word_t       wdata,
  input  logic        acc_valid,
  input  word_t       acc_addr,
  input  word_t       acc_data,
  input  logic [1:0]  acc_size,
  input  word_t       cyc_count,
  output word_t       ref_rd,
  output word_t       mask_rd,
  output word_t       func_rd,
  output logic        hit,
  output logic        enabled,
  output logic        cyc_sel,
  output logic        flag
);
  word_t              ref_q;
  logic [SHIFT_W-1:0] cnt_q;
  logic [3:0]         act_q;
  logic               cyc_q;
  logic               dmode_q;
  vsize_e             dsz_q;
  logic               flag_q;
  logic [SHIFT_W-1:0] shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      cnt_q   <= '0;
      act_q   <= '0;
      cyc_q   <= 1'b0;
      dmode_q <= 1'b0;
      dsz_q   <= SZ_BYTE;
      flag_q  <= 1'b0;
    end else begin
      if (wr_ref)  ref_q <= wdata;
      if (wr_mask) cnt_q <= wdata[SHIFT_W-1:0];
      if (wr_func) begin
        act_q   <= wdata[3:0];
        cyc_q   <= HAS_CYC ? wdata[FN_CYC] : 1'b0;
        dmode_q <= wdata[FN_DMODE];
        dsz_q   <= vsize_e'(wdata[FN_DSZ +: 2]);
      end
      // a fresh hit wins over a read-clear in the same cycle
      if (hit)          flag_q <= 1'b1;
      else if (rd_func) flag_q <= 1'b0;
    end
  end

  always_comb begin
    shift   = clamp_shift(cnt_q, MASK_LIMIT);
    enabled = (act_q != 4'd0);
    cyc_sel = cyc_q;
    if (!enabled)     hit = 1'b0;
    else if (cyc_q)   hit = window_hit(cyc_count, ref_q, shift);
    else if (dmode_q) hit = acc_valid && value_hit(acc_data, ref_q, dsz_q, acc_size);
    else              hit = acc_valid && window_hit(acc_addr, ref_q, shift);
  end

  assign flag    = flag_q;
  assign ref_rd  = ref_q;
  assign mask_rd = word_t'(cnt_q);
  assign func_rd = {7'd0, flag_q, 12'd0, dsz_q, 1'b0, dmode_q, cyc_q, 3'd0, act_q};
endmodule

// File: rtl/wpt_bank.sv
module wpt_bank
  import wpt_pkg::*;
#(
  parameter int unsigned        NUM_CMP    = 4,
  parameter int unsigned        BUS_AW     = 8,
  parameter int unsigned        REG_BASE   = 32,
  parameter int unsigned        REG_STRIDE = 16,
  parameter logic [SHIFT_W-1:0] MASK_LIMIT = 5'd15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [BUS_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               acc_valid,
  input  logic [31:0]        acc_addr,
  input  logic [31:0]        acc_data,
  input  logic [1:0]         acc_size,
  input  logic [31:0]        cyc_count,
  output logic [NUM_CMP-1:0] match_pulse
);
  logic [NUM_CMP-1:0] sel_ref, sel_mask, sel_func;
  logic [NUM_CMP-1:0] clr_vec, enab_vec, cyc_vec, flag_vec;
  word_t              ref_arr  [NUM_CMP];
  word_t              mask_arr [NUM_CMP];
  word_t              func_arr [NUM_CMP];

  wpt_decode #(
    .NUM_CMP(NUM_CMP), .BUS_AW(BUS_AW), .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE)
  ) u_decode (
    .reg_addr(reg_addr), .sel_ref(sel_ref), .sel_mask(sel_mask), .sel_func(sel_func)
  );

  assign clr_vec = sel_func & {NUM_CMP{reg_rd}};

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
    wpt_slot #(.HAS_CYC(i == 0), .MASK_LIMIT(MASK_LIMIT)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_ref(reg_wr && sel_ref[i]), .wr_mask(reg_wr && sel_mask[i]),
      .wr_func(reg_wr && sel_func[i]), .rd_func(clr_vec[i]),
      .wdata(reg_wdata),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_data(acc_data),
      .acc_size(acc_size), .cyc_count(cyc_count),
      .ref_rd(ref_arr[i]), .mask_rd(mask_arr[i]), .func_rd(func_arr[i]),
      .hit(match_pulse[i]), .enabled(enab_vec[i]), .cyc_sel(cyc_vec[i]),
      .flag(flag_vec[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (sel_ref[i])  reg_rdata = reg_rdata | ref_arr[i];
        if (sel_mask[i]) reg_rdata = reg_rdata | mask_arr[i];
        if (sel_func[i]) reg_rdata = reg_rdata | func_arr[i];
      end
    end
  end
endmodule

// File: rtl/wpt_bank_chk.sv
module wpt_bank_chk #(
  parameter int unsigned NUM_CMP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               reg_rd,
  input logic [31:0]        reg_rdata,
  input logic [NUM_CMP-1:0] match_pulse,
  input logic [NUM_CMP-1:0] flag_vec,
  input logic [NUM_CMP-1:0] enab_vec,
  input logic [NUM_CMP-1:0] cyc_vec,
  input logic [NUM_CMP-1:0] clr_vec,
  input logic [NUM_CMP-1:0] sel_func
);
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_p
    a_r5_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse[i] |=> flag_vec[i]);
    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_vec[i] && !clr_vec[i]) |=> flag_vec[i]);
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !match_pulse[i]) |=> !flag_vec[i]);
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !enab_vec[i] |-> !match_pulse[i]);
    a_r3_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && !cyc_vec[i]) |-> !match_pulse[i]);
    a_r4_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_vec[i] && !match_pulse[i]) |=> !flag_vec[i]);
    if (i > 0) begin : g_nc
      a_r8_no_cycle_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel_func[i]) |-> !reg_rdata[7]);
    end
  end
endmodule

bind wpt_bank wpt_bank_chk #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .match_pulse(match_pulse), .flag_vec(flag_vec),
  .enab_vec(enab_vec), .cyc_vec(cyc_vec), .clr_vec(clr_vec), .sel_func(sel_func)
);

// File: tb/wpt_bank_tb.sv
module wpt_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0, acc_data = '0, cyc_count = '0;
  logic [1:0]  acc_size = '0;
  logic [3:0]  match_pulse;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wpt_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_data(acc_data), .acc_size(acc_size),
    .cyc_count(cyc_count), .match_pulse(match_pulse)
  );

  function automatic logic [7:0] a_ref(input int n);  return 8'(32 + 16 * n); endfunction
  function automatic logic [7:0] a_msk(input int n);  return 8'(36 + 16 * n); endfunction
  function automatic logic [7:0] a_fn(input int n);   return 8'(40 + 16 * n); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic acc(input logic [31:0] ad, input logic [31:0] dt,
                     input logic [1:0] sz, output logic [3:0] p);
    @(negedge clk); acc_valid = 1'b1; acc_addr = ad; acc_data = dt; acc_size = sz;
    #1 p = match_pulse;
    @(negedge clk); acc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 96; a += 4) begin
      rd(8'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    #1 check("R1 no pulse", {28'd0, match_pulse}, 32'h0);

    // R2, R9, R8: register map and writable bits
    for (int n = 0; n < 4; n++) begin
      wr(a_ref(n), 32'hA5A5_0000 | n);
      wr(a_msk(n), 32'hFFFF_FFFF);
      wr(a_fn(n), 32'hFFFF_FFFF);
      wr(8'(44 + 16 * n), 32'hFFFF_FFFF);
      rd(a_ref(n), d);  check("R2 reference", d, 32'hA5A5_0000 | n);
      rd(a_msk(n), d);  check("R2 ignore count", d, 32'h1F);
      rd(a_fn(n), d);   check(n == 0 ? "R9 control comp0" : "R8 control no cycle bit",
                              d, n == 0 ? 32'h0000_0D8F : 32'h0000_0D0F);
      rd(8'(44 + 16 * n), d); check("R2 reserved", d, 32'h0);
      wr(a_fn(n), 32'h0);
      wr(a_msk(n), 32'h0);
    end
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R2 outside map", d, 32'h0);

    // R3: ignore count sweep on every comparator
    for (int c = 0; c < 4; c++) begin
      wr(a_ref(c), 32'h5A3C_96E1);
      wr(a_fn(c), 32'h1);
      for (int m = 0; m < 32; m++) begin
        int lim;
        lim = (m > 15) ? 15 : m;
        wr(a_msk(c), 32'(m));
        acc(32'h5A3C_96E1, 32'h0, 2'd2, p);
        check("R3 exact address", {28'd0, p}, 32'(1 << c));
        for (int k = 0; k < 20; k++) begin
          acc(32'h5A3C_96E1 ^ (32'h1 << k), 32'h0, 2'd2, p);
          check("R3 window", {28'd0, p}, (k < lim) ? 32'(1 << c) : 32'h0);
        end
      end
      wr(a_fn(c), 32'h0);
      wr(a_msk(c), 32'h0);
      rd(a_fn(c), d); check("R5 flag after sweep", d, 32'h0100_0000);
      rd(a_fn(c), d); check("R6 cleared after sweep", d, 32'h0);
    end

    // R4: action 0 disables
    wr(a_ref(0), 32'h1000);
    acc(32'h1000, 32'h0, 2'd2, p);
    check("R4 disabled pulse", {28'd0, p}, 32'h0);
    rd(a_fn(0), d); check("R4 disabled flag", d, 32'h0);

    // R5 / R6: flag set, held, cleared, and read colliding with a hit
    wr(a_fn(0), 32'h1);
    acc(32'h1000, 32'h0, 2'd2, p);
    check("R5 pulse same cycle", {28'd0, p}, 32'h1);
    #1 check("R5 pulse one clock", {28'd0, match_pulse}, 32'h0);
    repeat (5) @(negedge clk);
    rd(a_fn(0), d); check("R5 flag held", d, 32'h0100_0001);
    rd(a_fn(0), d); check("R6 read clears", d, 32'h0000_0001);
    wr(a_fn(0), 32'h1);
    rd(a_fn(0), d); check("R9 write keeps flag clear", d, 32'h0000_0001);
    acc(32'h1000, 32'h0, 2'd2, p);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a_fn(0);
    acc_valid = 1'b1; acc_addr = 32'h1000;
    #1 d = reg_rdata;
    check("R6 read during hit shows flag", d, 32'h0100_0001);
    @(negedge clk); reg_rd = 1'b0; acc_valid = 1'b0;
    rd(a_fn(0), d); check("R6 hit beats clear", d, 32'h0100_0001);
    rd(a_fn(0), d); check("R6 then clears", d, 32'h0000_0001);
    wr(a_fn(0), 32'h0);

    // R7: data-value mode sweep on comparator 2
    wr(a_ref(2), 32'h1234_5678);
    for (int ds = 0; ds < 4; ds++) begin
      wr(a_fn(2), 32'h101 | (ds << 10));
      for (int as = 0; as < 4; as++) begin
        for (int t = 0; t < 5; t++) begin
          int db;
          bit ok;
          db = (t == 0) ? -1 : ((t == 1) ? 3 : ((t == 2) ? 12 : ((t == 3) ? 20 : 28)));
          ok = (ds != 3) && (as == ds) && ((db < 0) || (db >= (8 << ds)));
          acc(32'h0, (db < 0) ? 32'h1234_5678 : (32'h1234_5678 ^ (32'h1 << db)),
              2'(as), p);
          check("R7 data value", {28'd0, p}, ok ? 32'h4 : 32'h0);
        end
      end
    end
    wr(a_fn(2), 32'h0);
    rd(a_fn(2), d);

    // R8: cycle mode on comparator 0 only
    wr(a_ref(0), 32'd100);
    wr(a_fn(0), 32'h181);
    @(negedge clk); cyc_count = 32'd100;
    #1 check("R8 cycle hit without access", {28'd0, match_pulse}, 32'h1);
    @(negedge clk); cyc_count = 32'd101;
    #1 check("R8 cycle miss", {28'd0, match_pulse}, 32'h0);
    wr(a_msk(0), 32'd2);
    @(negedge clk); cyc_count = 32'd103;
    #1 check("R8 cycle window hit", {28'd0, match_pulse}, 32'h1);
    @(negedge clk); cyc_count = 32'd104;
    #1 check("R8 cycle window miss", {28'd0, match_pulse}, 32'h0);
    wr(a_fn(0), 32'h0);
    wr(a_ref(1), 32'h200);
    wr(a_fn(1), 32'h81);
    @(negedge clk); cyc_count = 32'h200;
    #1 check("R8 comp1 ignores cycle", {28'd0, match_pulse}, 32'h0);
    acc(32'h200, 32'h0, 2'd2, p);
    check("R8 comp1 stays address mode", {28'd0, p}, 32'h2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule